// File: doc/BRIEF.md
# Load/Store Address Generator

This block sits between register read and the data memory port of a simple in-order core. For each single-word or single-byte transfer it forms the memory address from a base value and an offset. The offset is either a sign-extended immediate or a register value that passes through a logical shifter first. The block also forms the value that an updating addressing mode writes back into the base register.

Once a transfer is accepted, the block raises one memory request and holds it until the memory returns a one-cycle acknowledge. The request carries the size (byte or word), the direction, the byte enables and the lane-aligned store data. In the cycle of the acknowledge the block presents the formatted load data and, where the mode calls for it, the base writeback.

The caller picks one of four addressing modes:
- pre-indexed without update;
- pre-indexed with update;
- post-indexed;
- PC-relative.

Top module: `lsu_addr_gen`

## Requirements
- R1: Mode 0 (pre-indexed): `mem_addr` is base combined with the offset, and `wb_en` is never asserted.
- R2: Mode 1 (pre-indexed with update): `mem_addr` is base combined with the offset, and `wb_val` carries that same value with `wb_en` asserted in the acknowledge cycle.
- R3: Mode 2 (post-indexed): `mem_addr` is the unmodified base, and `wb_val` is base combined with the offset, with `wb_en` asserted in the acknowledge cycle.
- R4: When `use_reg_off`=1 (and mode is not 3), the offset is `roff_val` shifted by `shamt` (0..31), logically right when `shift_right`=1 and logically left otherwise. Otherwise the offset is `imm_off` sign-extended to 32 bits. The offset is added when `add_sel`=1 and subtracted when `add_sel`=0.
- R5: Mode 3 (PC-relative): `pc_val` replaces the base, and the sign-extended immediate is always used, whatever the value of `use_reg_off`. The address is formed as in pre-indexed mode, and `wb_en` is never asserted.
- R6: Transfer bits are decoded as follows. `xfer_load`=1 is a load (`mem_we`=0) and `xfer_load`=0 is a store (`mem_we`=1). `xfer_byte`=1 selects byte size (`mem_byte`=1) and `xfer_byte`=0 selects word size.
- R7: A byte load returns the byte on lane `mem_addr[1:0]` (lane k is `mem_rdata[8k+7:8k]`), zero-extended to 32 bits. A word load returns `mem_rdata` unchanged. In both cases `ld_valid`=1 only in the acknowledge cycle.
- R8: A byte store places `st_data[7:0]` on lane `mem_addr[1:0]` of `mem_wdata`, with all other bits zero, and sets only bit `mem_addr[1:0]` of `mem_be`. A word store drives `st_data` with `mem_be`=4'b1111.
- R9: A `start` seen while no request is pending raises `mem_req` on the next cycle. The request and all of its fields then stay stable until `mem_ack`, and `mem_req` drops in the cycle after the acknowledge. A `start` seen while a request is pending is ignored.
- R10: `wb_en` and `ld_valid` are asserted only while `mem_req` and `mem_ack` are both high.
- R11: After reset `mem_req`, `wb_en` and `ld_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer with the operands presented this cycle |
| mode | input | 2 | 0 pre, 1 pre with update, 2 post, 3 PC-relative |
| use_reg_off | input | 1 | Use shifted register offset instead of immediate |
| add_sel | input | 1 | 1 add offset, 0 subtract offset |
| shift_right | input | 1 | 1 logical right, 0 logical left |
| shamt | input | 5 | Shift amount for the register offset |
| imm_off | input | 12 | Signed immediate offset |
| base_val | input | 32 | Base register value |
| pc_val | input | 32 | Program counter value |
| roff_val | input | 32 | Offset register value |
| st_data | input | 32 | Store source value |
| xfer_byte | input | 1 | Byte-size transfer |
| xfer_load | input | 1 | Load transfer |
| mem_ack | input | 1 | One-cycle memory acknowledge |
| mem_rdata | input | 32 | Memory read data |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Write request |
| mem_byte | output | 1 | Byte-size request |
| mem_be | output | 4 | Byte enables |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Lane-aligned store data |
| ld_valid | output | 1 | Load data valid |
| ld_data | output | 32 | Formatted load data |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | 32 | Base writeback value |

## Verification
The captured transfer state shows up directly on `mem_addr`, `wb_val`, `mem_be` and `mem_wdata` in the first cycle of the request. A wrong offset, shift direction or mode selection is therefore visible one cycle after `start`. A lost or extra capture during a pending request shows as a field that changes before the acknowledge, or as a request that does not drop one cycle after it. The bench holds the acknowledge off for a varying number of cycles and checks every cycle in between. A wrong lane index or writeback qualifier only shows in the acknowledge cycle, on `ld_data` and `wb_en`, and the bench checks those in that cycle.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  typedef enum logic [1:0] {
    AM_PRE    = 2'd0,
    AM_PRE_UP = 2'd1,
    AM_POST   = 2'd2,
    AM_PCREL  = 2'd3
  } addr_mode_e;

  // Logical shift of a register offset; dir=1 selects right.
  function automatic logic [31:0] shift_offset(input logic [31:0] v,
                                               input logic [4:0] amt,
                                               input logic dir);
    return dir ? (v >> amt) : (v << amt);
  endfunction

  // Combine base with offset, adding or subtracting.
  function automatic logic [31:0] combine(input logic [31:0] base,
                                          input logic [31:0] off,
                                          input logic add);
    return add ? (base + off) : (base - off);
  endfunction
endpackage

// File: rtl/lsag_offset.sv
module lsag_offset #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12,
  parameter int SH_W  = 5
) (
  input  logic              use_reg,
  input  logic              pcrel,
  input  logic [XLEN-1:0]   roff,
  input  logic [SH_W-1:0]   shamt,
  input  logic              shdir,
  input  logic [IMM_W-1:0]  imm,
  output logic [XLEN-1:0]   off
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] reg_shifted;

  assign imm_ext     = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign reg_shifted = shdir ? (roff >> shamt) : (roff << shamt);

  // PC-relative always takes the immediate form.
  assign off = (use_reg && !pcrel) ? reg_shifted : imm_ext;
endmodule

// File: rtl/lsag_addr.sv
module lsag_addr #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] pc,
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] off,
  input  logic            add_sel,
  output logic [XLEN-1:0] eff,
  output logic [XLEN-1:0] upd,
  output logic            upd_want
);
  import lsag_pkg::*;

  addr_mode_e      m;
  logic [XLEN-1:0] src;
  logic [XLEN-1:0] sum;

  assign m   = addr_mode_e'(mode);
  assign src = (m == AM_PCREL) ? pc : base;
  assign sum = add_sel ? (src + off) : (src - off);

  always_comb begin
    eff      = sum;
    upd      = sum;
    upd_want = 1'b0;
    unique case (m)
      AM_PRE:    upd_want = 1'b0;
      AM_PRE_UP: upd_want = 1'b1;
      AM_POST: begin
        eff      = src;
        upd_want = 1'b1;
      end
      AM_PCREL:  upd_want = 1'b0;
      default:   upd_want = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsag_store_lane.sv
module lsag_store_lane #(
  parameter int XLEN = 32
) (
  input  logic                   byte_sz,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  logic [XLEN-1:0]        src,
  output logic [XLEN-1:0]        wdata,
  output logic [XLEN/8-1:0]      be
);
  localparam int NLANE = XLEN / 8;

  logic [NLANE-1:0] lane_hit;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign lane_hit[k]         = (lane == k[$clog2(NLANE)-1:0]);
    assign wdata[8*k +: 8]     = byte_sz ? (lane_hit[k] ? src[7:0] : 8'h00) : src[8*k +: 8];
    assign be[k]               = byte_sz ? lane_hit[k] : 1'b1;
  end
endmodule

// File: rtl/lsag_load_fmt.sv
module lsag_load_fmt #(
  parameter int XLEN = 32
) (
  input  logic                   byte_sz,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  logic [XLEN-1:0]        rdata,
  output logic [XLEN-1:0]        ldata
);
  localparam int NLANE = XLEN / 8;

  logic [7:0] picked;

  always_comb begin
    picked = 8'h00;
    for (int k = 0; k < NLANE; k++) begin
      if (lane == k[$clog2(NLANE)-1:0]) picked = rdata[8*k +: 8];
    end
  end

  assign ldata = byte_sz ? {{(XLEN-8){1'b0}}, picked} : rdata;
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12,
  parameter int SH_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              use_reg_off,
  input  logic              add_sel,
  input  logic              shift_right,
  input  logic [SH_W-1:0]   shamt,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   pc_val,
  input  logic [XLEN-1:0]   roff_val,
  input  logic [XLEN-1:0]   st_data,
  input  logic              xfer_byte,
  input  logic              xfer_load,
  input  logic              mem_ack,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_byte,
  output logic [XLEN/8-1:0] mem_be,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic              ld_valid,
  output logic [XLEN-1:0]   ld_data,
  output logic              wb_en,
  output logic [XLEN-1:0]   wb_val
);
  import lsag_pkg::*;

  localparam int NLANE  = XLEN / 8;
  localparam int LANE_W = $clog2(NLANE);

  // Internal events, named for the assertions.
  logic accept;
  logic done;
  logic pcrel_in;

  logic [XLEN-1:0]  off_c;
  logic [XLEN-1:0]  eff_c;
  logic [XLEN-1:0]  upd_c;
  logic             upd_want_c;
  logic [XLEN-1:0]  wdata_c;
  logic [NLANE-1:0] be_c;

  logic             req_q;
  logic [XLEN-1:0]  eff_q;
  logic [XLEN-1:0]  upd_q;
  logic             upd_want_q;
  logic [1:0]       mode_q;
  logic             byte_q;
  logic             load_q;
  logic [XLEN-1:0]  wdata_q;
  logic [NLANE-1:0] be_q;

  assign pcrel_in = (addr_mode_e'(mode) == AM_PCREL);
  assign accept   = start && !req_q;
  assign done     = req_q && mem_ack;

  lsag_offset #(.XLEN(XLEN), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
    .use_reg (use_reg_off),
    .pcrel   (pcrel_in),
    .roff    (roff_val),
    .shamt   (shamt),
    .shdir   (shift_right),
    .imm     (imm_off),
    .off     (off_c)
  );

  lsag_addr #(.XLEN(XLEN)) u_addr (
    .base     (base_val),
    .pc       (pc_val),
    .mode     (mode),
    .off      (off_c),
    .add_sel  (add_sel),
    .eff      (eff_c),
    .upd      (upd_c),
    .upd_want (upd_want_c)
  );

  lsag_store_lane #(.XLEN(XLEN)) u_st (
    .byte_sz (xfer_byte),
    .lane    (eff_c[LANE_W-1:0]),
    .src     (st_data),
    .wdata   (wdata_c),
    .be      (be_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      eff_q      <= '0;
      upd_q      <= '0;
      upd_want_q <= 1'b0;
      mode_q     <= 2'd0;
      byte_q     <= 1'b0;
      load_q     <= 1'b0;
      wdata_q    <= '0;
      be_q       <= '0;
    end else if (done) begin
      req_q <= 1'b0;
    end else if (accept) begin
      req_q      <= 1'b1;
      eff_q      <= eff_c;
      upd_q      <= upd_c;
      upd_want_q <= upd_want_c;
      mode_q     <= mode;
      byte_q     <= xfer_byte;
      load_q     <= xfer_load;
      wdata_q    <= wdata_c;
      be_q       <= be_c;
    end
  end

  lsag_load_fmt #(.XLEN(XLEN)) u_ld (
    .byte_sz (byte_q),
    .lane    (eff_q[LANE_W-1:0]),
    .rdata   (mem_rdata),
    .ldata   (ld_data)
  );

  assign mem_req   = req_q;
  assign mem_we    = !load_q;
  assign mem_byte  = byte_q;
  assign mem_be    = be_q;
  assign mem_addr  = eff_q;
  assign mem_wdata = wdata_q;
  assign wb_val    = upd_q;
  assign wb_en     = done && upd_want_q;
  assign ld_valid  = done && load_q;

  // R9: request and its fields hold while waiting for the acknowledge
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(wb_val) && $stable(mem_be));

  // R9: request drops right after the acknowledge
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_req);

  // R9: an accepted start always produces a request
  a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_req);

  // R10: side effects only in the acknowledge cycle
  a_r10_wb_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> mem_req && mem_ack);
  a_r10_ld_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> mem_req && mem_ack && !mem_we);

  // R1 / R5: no writeback for plain pre-indexed or PC-relative
  a_r5_no_pc_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (mode_q == 2'd1 || mode_q == 2'd2));

  // R8: byte request enables exactly one lane, word enables all
  a_r8_be: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_byte ? ($countones(mem_be) == 1) : (&mem_be)));

  // R11: idle after reset
  a_r11_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> !mem_req);
endmodule

// File: tb/lsu_addr_gen_test.sv
module lsu_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        use_reg_off = 1'b0;
  logic        add_sel = 1'b1;
  logic        shift_right = 1'b0;
  logic [4:0]  shamt = 5'd0;
  logic [11:0] imm_off = 12'd0;
  logic [31:0] base_val = 32'd0;
  logic [31:0] pc_val = 32'd0;
  logic [31:0] roff_val = 32'd0;
  logic [31:0] st_data = 32'd0;
  logic        xfer_byte = 1'b0;
  logic        xfer_load = 1'b0;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic        mem_req, mem_we, mem_byte, ld_valid, wb_en;
  logic [3:0]  mem_be;
  logic [31:0] mem_addr, mem_wdata, ld_data, wb_val;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  lsu_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .use_reg_off(use_reg_off), .add_sel(add_sel), .shift_right(shift_right),
    .shamt(shamt), .imm_off(imm_off), .base_val(base_val), .pc_val(pc_val),
    .roff_val(roff_val), .st_data(st_data), .xfer_byte(xfer_byte),
    .xfer_load(xfer_load), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ld_valid(ld_valid),
    .ld_data(ld_data), .wb_en(wb_en), .wb_val(wb_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference, written from the requirement text.
  int unsigned e_addr, e_wb, e_wdata, e_be;
  bit e_wben, e_we, e_byte;

  task automatic model(input int md, input bit ureg, input bit add, input bit rsh,
                       input int sh, input int imm, input int unsigned b,
                       input int unsigned pc, input int unsigned r,
                       input int unsigned sd, input bit byt, input bit ld);
    int unsigned o, s, src;
    int lane;
    src = (md == 3) ? pc : b;
    if (ureg && md != 3) o = rsh ? (r >> sh) : (r << sh);
    else o = (imm >= 2048) ? int'(imm) - 4096 : imm;
    s = add ? src + o : src - o;
    e_addr = (md == 2) ? src : s;
    e_wb   = s;
    e_wben = (md == 1 || md == 2);
    e_we   = !ld;
    e_byte = byt;
    lane   = e_addr % 4;
    e_wdata = byt ? ((sd & 32'hff) << (8 * lane)) : sd;
    e_be    = byt ? (1 << lane) : 4'hf;
  endtask

  // One transfer: ack after dly waiting cycles; optionally poke start while busy.
  task automatic xfer(input string tag, input int md, input bit ureg, input bit add,
                      input bit rsh, input int sh, input int imm, input int unsigned b,
                      input int unsigned pc, input int unsigned r, input int unsigned sd,
                      input bit byt, input bit ld, input int unsigned rd,
                      input int dly, input bit poke);
    int unsigned e_ld;
    model(md, ureg, add, rsh, sh, imm, b, pc, r, sd, byt, ld);
    @(negedge clk);
    mode = md[1:0]; use_reg_off = ureg; add_sel = add; shift_right = rsh;
    shamt = sh[4:0]; imm_off = imm[11:0]; base_val = b; pc_val = pc;
    roff_val = r; st_data = sd; xfer_byte = byt; xfer_load = ld; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R9 req raised"}, {31'd0, mem_req}, 32'd1);
    chk({tag, " addr"}, mem_addr, e_addr);
    chk({tag, " wb_val"}, wb_val, e_wb);
    chk({tag, " R6 we"}, {31'd0, mem_we}, {31'd0, e_we});
    chk({tag, " R6 byte"}, {31'd0, mem_byte}, {31'd0, e_byte});
    if (!ld) begin
      chk({tag, " R8 wdata"}, mem_wdata, e_wdata);
      chk({tag, " R8 be"}, {28'd0, mem_be}, e_be);
    end
    for (int i = 0; i < dly; i++) begin
      if (poke && i == 0) begin
        base_val = b ^ 32'h5a5a_0000; mode = 2'd2; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      chk({tag, " R9 held req"}, {31'd0, mem_req}, 32'd1);
      chk({tag, " R9 held addr"}, mem_addr, e_addr);
      chk({tag, " R10 no wb before ack"}, {31'd0, wb_en}, 32'd0);
      chk({tag, " R10 no ld before ack"}, {31'd0, ld_valid}, 32'd0);
    end
    mem_ack = 1'b1; mem_rdata = rd;
    #1;
    e_ld = byt ? ((rd >> (8 * (e_addr % 4))) & 32'hff) : rd;
    chk({tag, " R10 wb_en at ack"}, {31'd0, wb_en}, {31'd0, e_wben});
    chk({tag, " R7 ld_valid at ack"}, {31'd0, ld_valid}, {31'd0, ld});
    if (ld) chk({tag, " R7 ld_data"}, ld_data, e_ld);
    @(negedge clk);
    mem_ack = 1'b0;
    chk({tag, " R9 req dropped"}, {31'd0, mem_req}, 32'd0);
    chk({tag, " R10 wb off after"}, {31'd0, wb_en}, 32'd0);
    if (poke) begin
      @(negedge clk);
      chk({tag, " R9 busy start ignored"}, {31'd0, mem_req}, 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset req", {31'd0, mem_req}, 32'd0);
    chk("R11 reset wb_en", {31'd0, wb_en}, 32'd0);
    chk("R11 reset ld_valid", {31'd0, ld_valid}, 32'd0);
    rst_n = 1'b1;
    // R1 pre, immediate add, word load
    xfer("R1 pre imm", 0, 0, 1, 0, 0, 12'h010, 32'h1000, 0, 0, 0, 0, 1, 32'hdeadbeef, 2, 0);
    // R1 with negative immediate, subtract
    xfer("R1 pre neg sub", 0, 0, 0, 0, 0, 12'hffc, 32'h2000, 0, 0, 0, 0, 1, 32'h01234567, 0, 0);
    // R2 pre with update, register offset LSL
    xfer("R2 R4 lsl", 1, 1, 1, 0, 2, 0, 32'h4000, 0, 32'h3, 32'h0, 0, 1, 32'h55aa55aa, 1, 0);
    // R3 post, register offset LSR, subtract, byte store
    xfer("R3 R4 lsr", 2, 1, 0, 1, 4, 0, 32'h8003, 0, 32'h100, 32'hcafe_0077, 1, 0, 0, 3, 0);
    // R4 shift by 31
    xfer("R4 lsl31", 1, 1, 1, 0, 31, 0, 32'h10, 0, 32'h1, 32'h0, 0, 1, 32'h1, 0, 0);
    // R5 PC-relative, reg offset ignored
    xfer("R5 pcrel", 3, 1, 1, 0, 3, 12'h024, 32'h9999_0000, 32'h0000_0400, 32'hffff, 0, 0, 1, 32'h77, 1, 0);
    // R5 PC-relative subtract, byte store
    xfer("R5 pcrel sub", 3, 0, 0, 0, 0, 12'h002, 32'h0, 32'h0000_0104, 0, 32'h0000_00a5, 1, 0, 0, 0, 0);
    // R7 byte loads on lanes 1,2,3
    xfer("R7 lane1", 0, 0, 1, 0, 0, 12'h001, 32'h3000, 0, 0, 0, 1, 1, 32'h8899_aabb, 0, 0);
    xfer("R7 lane2", 1, 0, 1, 0, 0, 12'h002, 32'h3000, 0, 0, 0, 1, 1, 32'h8899_aabb, 2, 0);
    xfer("R7 lane3", 2, 0, 1, 0, 0, 12'h004, 32'h3003, 0, 0, 0, 1, 1, 32'h8899_aabb, 1, 0);
    // R8 word store and byte store lane 2
    xfer("R8 word st", 0, 0, 1, 0, 0, 12'h008, 32'h5000, 0, 0, 32'h1357_9bdf, 0, 0, 0, 1, 0);
    xfer("R8 byte st", 1, 0, 1, 0, 0, 12'h002, 32'h5000, 0, 0, 32'hffff_ff3c, 1, 0, 0, 0, 0);
    // R9 start while busy ignored
    xfer("R9 busy", 0, 0, 1, 0, 0, 12'h000, 32'h6000, 0, 0, 0, 0, 1, 32'h42, 3, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule